// File: doc/BRIEF.md
# Bus Cycle Command Generator

This block watches the three-bit cycle status a processor drives onto its bus and turns it into the command strobes a memory and I/O system needs. It produces separate active-low strobes for memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also produces a data-direction control for the data transceiver, a registered upper-byte enable, and a flag that shows the processor has halted.

A bus cycle begins when the status moves off the all-ones idle code. The block records which kind of cycle it is and then steps through its own T1, T2 and T3 phases. The command strobe turns on at T2 and stays on for every T3 clock in which the synchronized ready input is low. The strobe turns off at the first T3 edge that sees ready high. The cycle is over once the status has gone back to the idle code. The processor may return the status to idle early, while wait states are still running, and this does not cut the strobe short.

Top module: `bus_cmd_gen`

## Requirements
- R1: While reset is high and after it is released, all five strobes are high, dir_tx is high, hi_en_n is high and halted is low.
- R2: A cycle starts only on the first clock edge at which stat differs from 3'b111 after an edge at which it was 3'b111. A status change in the middle of a cycle, from one non-idle code to another, starts nothing.
- R3: The strobes map to status codes as follows. 3'b000 drives ack_n, 3'b001 drives io_rd_n, 3'b010 drives io_wr_n, 3'b100 and 3'b101 both drive mem_rd_n, and 3'b110 drives mem_wr_n.
- R4: Code 3'b011 (halt) drives no strobe. It sets halted from the start edge until the next cycle starts. Code 3'b111 drives nothing.
- R5: The strobe goes low after the second clock edge of the cycle. With ready high at the first T3 edge, it stays low for exactly two clocks.
- R6: Each T3 edge with rdy low extends the strobe by one clock. The strobe rises after the first T3 edge with rdy high. rdy has no effect during T1 and T2.
- R7: dir_tx is low for acknowledge, I/O read, code fetch and memory read cycles. It is high for write and halt cycles. It is set at the start edge, held until the cycle ends, and high when idle.
- R8: hi_en_n takes bhe_n as sampled at the start edge and holds that value through the cycle, even if bhe_n changes later in the cycle. It is high when idle.
- R9: If stat has returned to 3'b111 by the releasing T3 edge, the block goes idle at that edge. Otherwise it goes idle at the first later edge that sees 3'b111. An early return to idle during wait states does not shorten the strobe.
- R10: At most one strobe is low in any clock.
- R11: A new cycle may start at the edge right after the edge that ended the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stat | input | 3 | Cycle status from the processor |
| rdy | input | 1 | Synchronized ready, high when the transfer is done |
| bhe_n | input | 1 | Upper byte enable from the processor, active low |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| ack_n | output | 1 | Interrupt acknowledge strobe, active low |
| dir_tx | output | 1 | Transceiver direction, high to transmit and low to receive |
| hi_en_n | output | 1 | Upper byte enable held for the cycle, active low |
| halted | output | 1 | High after a halt cycle has started |

## Verification
Two things can happen at the same clock edge: the strobe releasing on ready, and the cycle ending because the status is already back at idle. The bench provokes this by returning stat to 3'b111 during wait states and raising rdy later. It expects the strobe and dir_tx to change at that single edge. In a second pattern the status is still non-idle when ready rises. There the bench expects the strobe to release first and dir_tx to return high only at a later edge. Each of these endings is followed at once by the next cycle's start, to show that the end of one cycle and the start of the next fall on adjacent edges without a lost clock.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;
  localparam int STAT_W = 3;
  localparam int CMD_N  = 5;

  localparam logic [STAT_W-1:0] CODE_IDLE = 3'b111;
  localparam logic [STAT_W-1:0] CODE_HALT = 3'b011;

  // strobe bit positions inside the command vector
  localparam int CMD_ACK  = 4;
  localparam int CMD_IORD = 3;
  localparam int CMD_IOWR = 2;
  localparam int CMD_MRD  = 1;
  localparam int CMD_MWR  = 0;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_DONE = 3'd4
  } phase_t;

  // active-high command selected by a status code
  function automatic logic [CMD_N-1:0] cmd_mask(input logic [STAT_W-1:0] code);
    logic [CMD_N-1:0] m;
    m = '0;
    case (code)
      3'b000:         m[CMD_ACK]  = 1'b1;
      3'b001:         m[CMD_IORD] = 1'b1;
      3'b010:         m[CMD_IOWR] = 1'b1;
      3'b100, 3'b101: m[CMD_MRD]  = 1'b1;
      3'b110:         m[CMD_MWR]  = 1'b1;
      default:        m = '0;
    endcase
    return m;
  endfunction

  // cycles that move data toward the processor
  function automatic logic code_receives(input logic [STAT_W-1:0] code);
    return (code == 3'b000) || (code == 3'b001) ||
           (code == 3'b100) || (code == 3'b101);
  endfunction
endpackage

// File: rtl/bus_cycle_detect.sv
module bus_cycle_detect
  import bus_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat,
  input  logic              idle,
  output logic              cyc_start,
  output logic              stat_idle
);
  logic [STAT_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= CODE_IDLE;
    else     prev_q <= stat;
  end

  assign stat_idle = (stat == CODE_IDLE);
  assign cyc_start = idle && (prev_q == CODE_IDLE) && !stat_idle;

  p_start_after_idle_r2: assert property (@(posedge clk) disable iff (rst)
    cyc_start |-> ($past(stat) == CODE_IDLE));
endmodule

// File: rtl/bus_phase_fsm.sv
module bus_phase_fsm
  import bus_cmd_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   cyc_start,
  input  logic   stat_idle,
  input  logic   rdy,
  output phase_t phase,
  output logic   strobe_win,
  output logic   active
);
  phase_t nxt;

  always_comb begin
    nxt = phase;
    case (phase)
      PH_IDLE: if (cyc_start) nxt = PH_T1;
      PH_T1:   nxt = PH_T2;
      PH_T2:   nxt = PH_T3;
      PH_T3:   if (rdy) nxt = stat_idle ? PH_IDLE : PH_DONE;
      PH_DONE: if (stat_idle) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= nxt;
  end

  assign strobe_win = (phase == PH_T2) || (phase == PH_T3);
  assign active     = (phase != PH_IDLE);

  p_t1_then_t2_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_T1) |=> (phase == PH_T2));
  p_wait_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_T3 && !rdy) |=> strobe_win);
  p_ready_releases_r6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_T3 && rdy) |=> !strobe_win);
endmodule

// File: rtl/bus_cycle_regs.sv
module bus_cycle_regs
  import bus_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_start,
  input  logic              active,
  input  logic [STAT_W-1:0] stat,
  input  logic              bhe_n,
  output logic [STAT_W-1:0] code,
  output logic              dir_tx,
  output logic              hi_en_n,
  output logic              halted
);
  logic dir_q, bhe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code   <= CODE_IDLE;
      dir_q  <= 1'b1;
      bhe_q  <= 1'b1;
      halted <= 1'b0;
    end else if (cyc_start) begin
      code   <= stat;
      dir_q  <= !code_receives(stat);
      bhe_q  <= bhe_n;
      halted <= (stat == CODE_HALT);
    end
  end

  assign dir_tx  = active ? dir_q : 1'b1;
  assign hi_en_n = active ? bhe_q : 1'b1;

  p_bhe_held_r8: assert property (@(posedge clk) disable iff (rst)
    (active && !cyc_start) |=> (active -> $stable(hi_en_n)));
endmodule

// File: rtl/bus_cmd_decode.sv
module bus_cmd_decode
  import bus_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] code,
  input  logic              strobe_win,
  output logic [CMD_N-1:0]  cmd_n
);
  assign cmd_n = ~(cmd_mask(code) & {CMD_N{strobe_win}});

  p_no_strobe_outside_r5: assert property (@(posedge clk) disable iff (rst)
    !strobe_win |-> (&cmd_n));
endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
  import bus_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  stat,
  input  logic        rdy,
  input  logic        bhe_n,
  output logic        mem_rd_n,
  output logic        mem_wr_n,
  output logic        io_rd_n,
  output logic        io_wr_n,
  output logic        ack_n,
  output logic        dir_tx,
  output logic        hi_en_n,
  output logic        halted
);
  phase_t            phase;
  logic              cyc_start, stat_idle, strobe_win, active;
  logic [STAT_W-1:0] code;
  logic [CMD_N-1:0]  cmd_n;

  bus_cycle_detect u_detect (
    .clk(clk), .rst(rst), .stat(stat), .idle(phase == PH_IDLE),
    .cyc_start(cyc_start), .stat_idle(stat_idle)
  );

  bus_phase_fsm u_fsm (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .stat_idle(stat_idle),
    .rdy(rdy), .phase(phase), .strobe_win(strobe_win), .active(active)
  );

  bus_cycle_regs u_regs (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .active(active),
    .stat(stat), .bhe_n(bhe_n), .code(code), .dir_tx(dir_tx),
    .hi_en_n(hi_en_n), .halted(halted)
  );

  bus_cmd_decode u_decode (
    .clk(clk), .rst(rst), .code(code), .strobe_win(strobe_win), .cmd_n(cmd_n)
  );

  assign ack_n    = cmd_n[CMD_ACK];
  assign io_rd_n  = cmd_n[CMD_IORD];
  assign io_wr_n  = cmd_n[CMD_IOWR];
  assign mem_rd_n = cmd_n[CMD_MRD];
  assign mem_wr_n = cmd_n[CMD_MWR];

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cmd_n));
  p_halt_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    halted |-> (&cmd_n));
  p_dir_held_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_T3) |-> $stable(dir_tx));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> ((&cmd_n) && dir_tx && hi_en_n));
endmodule

// File: tb/bus_cmd_gen_test.sv
module bus_cmd_gen_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] stat = 3'b111;
  logic rdy = 1'b1;
  logic bhe_n = 1'b1;
  logic mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, ack_n, dir_tx, hi_en_n, halted;

  int errors = 0;
  int checks = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       halt_exp = 1'b0;
  bit         finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cmd_gen uut (
    .clk(clk), .rst(rst), .stat(stat), .rdy(rdy), .bhe_n(bhe_n),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
    .io_wr_n(io_wr_n), .ack_n(ack_n), .dir_tx(dir_tx),
    .hi_en_n(hi_en_n), .halted(halted)
  );

  function automatic logic [7:0] observed();
    return {ack_n, io_rd_n, io_wr_n, mem_rd_n, mem_wr_n, dir_tx, hi_en_n, halted};
  endfunction

  // low bit = strobe active; order ack, iord, iowr, mrd, mwr (R3)
  function automatic logic [4:0] strobes_for(input logic [2:0] c);
    logic [4:0] s;
    s = 5'b11111;
    if (c == 3'd0) s[4] = 1'b0;
    if (c == 3'd1) s[3] = 1'b0;
    if (c == 3'd2) s[2] = 1'b0;
    if (c[2:1] == 2'b10) s[1] = 1'b0;
    if (c == 3'd6) s[0] = 1'b0;
    return s;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] s, input logic r, input logic b,
                      input logic [7:0] exp, input string tag);
    @(negedge clk);
    stat = s; rdy = r; bhe_n = b;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // monitor: compares the outputs just after each edge with the queued item
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(observed(), exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic run_bus(input logic [2:0] c, input logic b, input int waits,
                         input bit early, input bit glitch, input string tag);
    logic [4:0] on;
    logic d;
    logic [2:0] late;
    on = strobes_for(c);
    d = !(c == 3'd0 || c == 3'd1 || c == 3'd4 || c == 3'd5);
    halt_exp = (c == 3'd3);
    late = early ? 3'b111 : c;
    step(c, 1'b0, b, {5'b11111, d, b, halt_exp}, tag);          // start edge -> T1
    step(c, 1'b0, ~b, {on, d, b, halt_exp}, tag);               // T2, rdy ignored
    step(c, 1'b0, ~b, {on, d, b, halt_exp}, tag);               // T3
    for (int w = 0; w < waits; w++)
      step(late, 1'b0, ~b, {on, d, b, halt_exp}, tag);          // wait states
    if (early) begin
      step(3'b111, 1'b1, ~b, {5'b11111, 1'b1, 1'b1, halt_exp}, tag);
    end else begin
      step(c, 1'b1, ~b, {5'b11111, d, b, halt_exp}, tag);
      if (glitch)
        step((c == 3'd5) ? 3'd6 : 3'd5, 1'b1, ~b, {5'b11111, d, b, halt_exp}, tag);
      step(3'b111, 1'b1, 1'b1, {5'b11111, 1'b1, 1'b1, halt_exp}, tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(observed(), 8'b11111_1_1_0, "R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check(observed(), 8'b11111_1_1_0, "R1 after reset");

    run_bus(3'd0, 1'b0, 0, 1'b0, 1'b0, "R3 R7 R10 ack");
    run_bus(3'd1, 1'b1, 0, 1'b0, 1'b0, "R3 R7 R8 io read");
    run_bus(3'd2, 1'b0, 1, 1'b0, 1'b0, "R3 R7 R8 io write");
    run_bus(3'd4, 1'b1, 0, 1'b1, 1'b0, "R3 R5 code fetch");
    run_bus(3'd5, 1'b0, 3, 1'b0, 1'b0, "R6 R3 memory read waits");
    run_bus(3'd6, 1'b1, 0, 1'b0, 1'b0, "R3 R5 R7 memory write");
    run_bus(3'd3, 1'b0, 0, 1'b0, 1'b0, "R4 halt");
    repeat (3) step(3'b111, 1'b1, 1'b0, {5'b11111, 1'b1, 1'b1, 1'b1}, "R4 idle after halt");
    run_bus(3'd5, 1'b0, 2, 1'b1, 1'b0, "R9 early idle during waits");
    run_bus(3'd6, 1'b0, 0, 1'b1, 1'b0, "R11 R9 back to back write");
    run_bus(3'd1, 1'b1, 1, 1'b0, 1'b1, "R2 mid cycle status change");
    run_bus(3'd0, 1'b0, 2, 1'b0, 1'b0, "R11 R6 back to back ack");

    wait (exp_q.size() == 0);
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule